// File: doc/BRIEF.md
# Framed Serial Slave Shifter

This block is a serial-peripheral slave that moves 16-bit words in both directions on a free-running external serial clock. Word boundaries are not marked by a held chip-select level. A frame-sync line carries a pulse one serial-clock period wide that marks the first bit of each word. A direction control picks who owns that line. With direction 0 the block drives the pulse itself as soon as software loads a word. With direction 1 the block waits for a pulse from the far end, then starts shifting on the next transmit edge.

The serial clock, the data input and the frame-sync input are brought into the system clock domain by two-flop synchronizers. Clock edges are found from the synchronized clock, so the serial clock may run at no more than a quarter of the system clock rate. Software writes words into a one-deep transmit buffer and reads received words from a one-deep receive buffer. Each buffer has a full flag, and the receive side also has an overflow flag. Transfers run only while master operation is off and framing is on.

Top module: `framed_spi_slave`

## Requirements
- R1: Framed operation is active only while masterEn is 0 and frameEn is 1. Otherwise fsyncOut, fsyncOe and sdoOut stay 0 and no frame starts. A word written while inactive is held (txFull stays 1) and is sent once operation becomes active.
- R2: While active, fsyncOe is 1 when syncDir is 0 (the block drives frame sync) and 0 when syncDir is 1 (frame sync is an input). When driven, fsyncOut idles at 0.
- R3: With syncDir 0, a transmit-buffer write makes fsyncOut go to 1 on the next transmit edge of the serial clock. It stays 1 for exactly one serial-clock period. The first data bit appears on sdoOut on that same edge.
- R4: With syncDir 1, fsyncIn (active high) is sampled on the sample edge. When it is sampled as 1, the word starts shifting on the following transmit edge. Before that, sdoOut is 0.
- R5: Words are 16 bits and are sent MSB first, one bit per transmit edge. clkPol 0 makes the falling edge the transmit edge and the rising edge the sample edge. clkPol 1 swaps the two.
- R6: sdiIn is captured on each sample edge of a frame, MSB first. After the 16th bit, the word appears on rxData and rxFull goes to 1.
- R7: If a word completes while rxFull is 1 and no read occurs in that cycle, the word is dropped, rxData keeps the earlier word and rxOverflow goes to 1. A one-cycle rxRead pulse clears rxFull and rxOverflow.
- R8: txFull goes to 1 on a txWrite and returns to 0 when the word loads into the shifter at frame start. A write while txFull is 1 replaces the buffered word.
- R9: With syncDir 1, a frame that starts with no word buffered (txFull 0) sends sixteen zeros.
- R10: After reset, txFull, rxFull, rxOverflow, sdoOut and fsyncOut are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| masterEn | input | 1 | Master operation request; framed slave operation needs 0 |
| frameEn | input | 1 | Framing enable; framed slave operation needs 1 |
| syncDir | input | 1 | 0: block drives frame sync, 1: block receives frame sync |
| clkPol | input | 1 | 0: transmit on falling edge, 1: transmit on rising edge |
| sclkIn | input | 1 | Free-running serial clock |
| sdiIn | input | 1 | Serial data in |
| sdoOut | output | 1 | Serial data out |
| fsyncIn | input | 1 | Frame-sync pin input value |
| fsyncOut | output | 1 | Frame-sync pin drive value |
| fsyncOe | output | 1 | Frame-sync pin output enable |
| txWrite | input | 1 | Transmit-buffer write strobe |
| txData | input | 16 | Word to transmit |
| txFull | output | 1 | Transmit buffer holds an unsent word |
| rxRead | input | 1 | Receive-buffer read strobe |
| rxData | output | 16 | Last accepted received word |
| rxFull | output | 1 | Receive buffer holds an unread word |
| rxOverflow | output | 1 | A completed word was dropped |

## Verification
The bench uses the default parameters: a 16-bit word and two synchronizer stages. The serial clock runs at one tenth of the system clock. That leaves room for the three-cycle synchronizer and edge latency inside each half period, so the bench can act as a peer on the far end of the line. It samples sdoOut and fsyncOut on its own serial-clock edges and feeds sdiIn on its transmit edges. Random frames vary polarity, sync direction, the data words, whether a word was written and whether the receive buffer is read. This exercises pulse generation, pulse reception, zero fill, overflow and the inactive mode on both clock polarities.

// File: rtl/fspi_pkg.sv
package fspi_pkg;

  // Strobes that the control unit issues to the datapath each system cycle
  typedef struct packed {
    logic loadBuf;   // move transmit buffer into the shifter
    logic loadZero;  // clear the shifter (no word pending)
    logic shift;     // advance transmit shifter by one bit
    logic capture;   // shift one received bit in
    logic commit;    // move completed word into the receive buffer
  } fspiStrobe_t;

endpackage

// File: rtl/fspi_edge.sv
module fspi_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic sdiIn,
  input  logic fsyncIn,
  output logic sclkRise,
  output logic sclkFall,
  output logic sdiS,
  output logic fsyncS
);

  // The serial clock pipe has one extra stage that holds the previous value
  logic [SYNC_STAGES:0]   sclkPipe;
  logic [SYNC_STAGES-1:0] sdiPipe;
  logic [SYNC_STAGES-1:0] fsPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      sdiPipe  <= '0;
      fsPipe   <= '0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-1:0], sclkIn};
      sdiPipe  <= {sdiPipe[SYNC_STAGES-2:0], sdiIn};
      fsPipe   <= {fsPipe[SYNC_STAGES-2:0], fsyncIn};
    end
  end

  assign sclkRise = sclkPipe[SYNC_STAGES-1] & ~sclkPipe[SYNC_STAGES];
  assign sclkFall = ~sclkPipe[SYNC_STAGES-1] & sclkPipe[SYNC_STAGES];
  assign sdiS     = sdiPipe[SYNC_STAGES-1];
  assign fsyncS   = fsPipe[SYNC_STAGES-1];

endmodule

// File: rtl/fspi_ctrl.sv
module fspi_ctrl
  import fspi_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        active,
  input  logic        syncDir,
  input  logic        clkPol,
  input  logic        sclkRise,
  input  logic        sclkFall,
  input  logic        fsyncS,
  input  logic        txWrite,
  input  logic        rxRead,
  output fspiStrobe_t strobe,
  output logic        busy,
  output logic        fsyncDrive,
  output logic        txFull,
  output logic        rxFull,
  output logic        rxOverflow
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(WORD_W);

  logic [CNT_W-1:0] txCnt;
  logic [CNT_W-1:0] rxCnt;
  logic syncSeen;

  logic txEdge, smpEdge, lastBit, startCond;
  logic frameStart, shiftNow, endNow, captureNow, wordDone;

  always_comb begin
    txEdge     = clkPol ? sclkRise : sclkFall;
    smpEdge    = clkPol ? sclkFall : sclkRise;
    lastBit    = (txCnt == LAST_IDX);
    startCond  = syncDir ? syncSeen : txFull;
    frameStart = active && txEdge && (!busy || lastBit) && startCond;
    shiftNow   = active && txEdge && busy && !lastBit;
    endNow     = active && txEdge && busy && lastBit && !startCond;
    captureNow = active && smpEdge && busy && (rxCnt < WORD_CNT);
    wordDone   = captureNow && (rxCnt == LAST_IDX);

    strobe          = '0;
    strobe.loadBuf  = frameStart && txFull;
    strobe.loadZero = frameStart && !txFull;
    strobe.shift    = shiftNow;
    strobe.capture  = captureNow;
    strobe.commit   = wordDone && (!rxFull || rxRead);
  end

  // Frame sequencing: bit counters and busy flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      txCnt <= '0;
      rxCnt <= '0;
    end else if (!active) begin
      busy  <= 1'b0;
      txCnt <= '0;
      rxCnt <= '0;
    end else begin
      if (frameStart) begin
        busy  <= 1'b1;
        txCnt <= '0;
        rxCnt <= '0;
      end else begin
        if (endNow)     busy  <= 1'b0;
        if (shiftNow)   txCnt <= txCnt + CNT_W'(1);
        if (captureNow) rxCnt <= rxCnt + CNT_W'(1);
      end
    end
  end

  // Frame-sync handling for both directions
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncSeen   <= 1'b0;
      fsyncDrive <= 1'b0;
    end else if (!active) begin
      syncSeen   <= 1'b0;
      fsyncDrive <= 1'b0;
    end else begin
      if (!syncDir || txEdge) syncSeen <= 1'b0;
      else if (smpEdge)       syncSeen <= fsyncS;
      if (syncDir)            fsyncDrive <= 1'b0;
      else if (txEdge)        fsyncDrive <= frameStart;
    end
  end

  // Buffer status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFull     <= 1'b0;
      rxFull     <= 1'b0;
      rxOverflow <= 1'b0;
    end else begin
      if (txWrite)         txFull <= 1'b1;
      else if (frameStart) txFull <= 1'b0;

      if (strobe.commit) rxFull <= 1'b1;
      else if (rxRead)   rxFull <= 1'b0;

      if (wordDone && rxFull && !rxRead) rxOverflow <= 1'b1;
      else if (rxRead)                   rxOverflow <= 1'b0;
    end
  end

endmodule

// File: rtl/fspi_datapath.sv
module fspi_datapath
  import fspi_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fspiStrobe_t       strobe,
  input  logic              txWrite,
  input  logic [WORD_W-1:0] txData,
  input  logic              sdiS,
  output logic              txMsb,
  output logic [WORD_W-1:0] rxData
);

  logic [WORD_W-1:0] txBuf;
  logic [WORD_W-1:0] txShift;
  logic [WORD_W-2:0] rxShift;   // bits received so far, newest in bit 0

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf   <= '0;
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
    end else begin
      if (txWrite) txBuf <= txData;

      if (strobe.loadBuf)       txShift <= txBuf;
      else if (strobe.loadZero) txShift <= '0;
      else if (strobe.shift)    txShift <= {txShift[WORD_W-2:0], 1'b0};

      if (strobe.capture) rxShift <= {rxShift[WORD_W-3:0], sdiS};
      if (strobe.commit)  rxData  <= {rxShift, sdiS};
    end
  end

  assign txMsb = txShift[WORD_W-1];

endmodule

// File: rtl/framed_spi_slave.sv
module framed_spi_slave
  import fspi_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterEn,
  input  logic              frameEn,
  input  logic              syncDir,
  input  logic              clkPol,
  input  logic              sclkIn,
  input  logic              sdiIn,
  output logic              sdoOut,
  input  logic              fsyncIn,
  output logic              fsyncOut,
  output logic              fsyncOe,
  input  logic              txWrite,
  input  logic [WORD_W-1:0] txData,
  output logic              txFull,
  input  logic              rxRead,
  output logic [WORD_W-1:0] rxData,
  output logic              rxFull,
  output logic              rxOverflow
);

  logic sclkRise, sclkFall, sdiS, fsyncS;
  logic active, busy, fsyncDrive, txMsb;
  fspiStrobe_t strobe;

  assign active = !masterEn && frameEn;

  fspi_edge #(.SYNC_STAGES(SYNC_STAGES)) uEdge (
    .clk(clk), .rstN(rstN),
    .sclkIn(sclkIn), .sdiIn(sdiIn), .fsyncIn(fsyncIn),
    .sclkRise(sclkRise), .sclkFall(sclkFall),
    .sdiS(sdiS), .fsyncS(fsyncS)
  );

  fspi_ctrl #(.WORD_W(WORD_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .active(active), .syncDir(syncDir), .clkPol(clkPol),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .fsyncS(fsyncS),
    .txWrite(txWrite), .rxRead(rxRead),
    .strobe(strobe), .busy(busy), .fsyncDrive(fsyncDrive),
    .txFull(txFull), .rxFull(rxFull), .rxOverflow(rxOverflow)
  );

  fspi_datapath #(.WORD_W(WORD_W)) uData (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .txWrite(txWrite), .txData(txData),
    .sdiS(sdiS), .txMsb(txMsb), .rxData(rxData)
  );

  assign sdoOut   = active && busy && txMsb;
  assign fsyncOut = active && fsyncDrive;
  assign fsyncOe  = active && !syncDir;

endmodule

// File: rtl/fspi_checker.sv
module fspi_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              masterEn,
  input logic              frameEn,
  input logic              syncDir,
  input logic              sdoOut,
  input logic              fsyncOut,
  input logic              txWrite,
  input logic              txFull,
  input logic              rxRead,
  input logic [WORD_W-1:0] rxData,
  input logic              rxFull,
  input logic              rxOverflow
);

  a_r1_quiet_inactive: assert property (@(posedge clk) disable iff (!rstN)
    (masterEn || !frameEn) |-> (!fsyncOut && !sdoOut));

  a_r3_pulse_gen_only: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fsyncOut) |-> !syncDir);

  a_r3_pulse_not_glitch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fsyncOut) |=> (fsyncOut || masterEn || !frameEn || syncDir));

  a_r7_hold_unread: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !rxRead) |=> $stable(rxData));

  a_r7_overflow_needs_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverflow) |-> $past(rxFull));

  a_r8_write_sets_full: assert property (@(posedge clk) disable iff (!rstN)
    txWrite |=> txFull);

endmodule

bind framed_spi_slave fspi_checker #(.WORD_W(WORD_W)) uChk (
  .clk(clk), .rstN(rstN), .masterEn(masterEn), .frameEn(frameEn),
  .syncDir(syncDir), .sdoOut(sdoOut), .fsyncOut(fsyncOut),
  .txWrite(txWrite), .txFull(txFull), .rxRead(rxRead),
  .rxData(rxData), .rxFull(rxFull), .rxOverflow(rxOverflow)
);

// File: tb/sim_framed_spi_slave.sv
module sim_framed_spi_slave;

  logic clk = 0, rstN = 0, sclk = 0, sdi = 0, fsyncIn = 0;
  logic masterEn = 0, frameEn = 1, syncDir = 0, clkPol = 0;
  logic txWrite = 0, rxRead = 0;
  logic [15:0] txData = '0;
  logic sdoOut, fsyncOut, fsyncOe, txFull, rxFull, rxOverflow;
  logic [15:0] rxData;

  framed_spi_slave u0 (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .frameEn(frameEn),
    .syncDir(syncDir), .clkPol(clkPol), .sclkIn(sclk), .sdiIn(sdi),
    .sdoOut(sdoOut), .fsyncIn(fsyncIn), .fsyncOut(fsyncOut), .fsyncOe(fsyncOe),
    .txWrite(txWrite), .txData(txData), .txFull(txFull),
    .rxRead(rxRead), .rxData(rxData), .rxFull(rxFull), .rxOverflow(rxOverflow)
  );

  always #4 clk = ~clk;                 // 125 MHz
  initial begin #2; forever #40 sclk = ~sclk; end  // serial clock, 1/10 rate

  int checks = 0, errors = 0;
  bit finished = 0;
  logic rxFullExp = 0, ovfExp = 0;
  logic [15:0] rxBufExp = '0;
  int unsigned seedVal;

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] txExpect(bit wrote, logic [15:0] w);
    return wrote ? w : 16'h0000;
  endfunction

  task automatic waitTx();
    if (clkPol) @(posedge sclk); else @(negedge sclk);
  endtask

  task automatic waitSample();
    if (clkPol) @(negedge sclk); else @(posedge sclk);
  endtask

  task automatic writeWord(logic [15:0] w);
    @(negedge clk); txWrite = 1; txData = w;
    @(negedge clk); txWrite = 0;
    check("R8 txFull after write", txFull, 1);
  endtask

  task automatic doRead();
    @(negedge clk); rxRead = 1;
    @(negedge clk); rxRead = 0;
    rxFullExp = 0; ovfExp = 0;
    @(negedge clk);
    check("R7 rxFull cleared by read", rxFull, 0);
    check("R7 overflow cleared by read", rxOverflow, 0);
  endtask

  task automatic afterFrame(logic [15:0] rxw);
    repeat (3) @(negedge clk);
    if (rxFullExp) ovfExp = 1;
    else begin rxBufExp = rxw; rxFullExp = 1; end
    check("R6 rxFull", rxFull, rxFullExp);
    check("R6 rxData", rxData, rxBufExp);
    check("R7 overflow", rxOverflow, ovfExp);
    check("R8 txFull after load", txFull, 0);
    repeat (2) waitTx();
  endtask

  task automatic runGen(bit doWrite, logic [15:0] w, logic [15:0] rxw, logic [15:0] expTx);
    logic [15:0] got;
    time t0;
    if (doWrite) writeWord(w);
    t0 = $time;
    @(posedge fsyncOut);
    if (doWrite) check("R3 pulse on next transmit edge", ($time - t0) <= 110, 1);
    #1 sdi = rxw[15];
    check("R2 fsyncOe in drive mode", fsyncOe, 1);
    for (int k = 0; k < 16; k++) begin
      if (k > 0) begin waitTx(); sdi = rxw[15-k]; end
      waitSample();
      got[15-k] = sdoOut;
      if (k == 0) check("R3 pulse high first period", fsyncOut, 1);
      if (k == 1) check("R3 pulse low second period", fsyncOut, 0);
    end
    check("R5 R3 transmitted word", got, expTx);
    afterFrame(rxw);
  endtask

  task automatic runRecv(logic [15:0] rxw, logic [15:0] expTx);
    logic [15:0] got;
    waitTx(); fsyncIn = 1;
    waitSample();
    check("R4 sdo idle before sync", sdoOut, 0);
    check("R2 fsyncOe in receive mode", fsyncOe, 0);
    waitTx(); fsyncIn = 0; sdi = rxw[15];
    for (int k = 0; k < 16; k++) begin
      if (k > 0) begin waitTx(); sdi = rxw[15-k]; end
      waitSample();
      got[15-k] = sdoOut;
    end
    check("R4 R5 R9 transmitted word", got, expTx);
    afterFrame(rxw);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish();
  end

  initial begin
    seedVal = $urandom(32'h5EED);
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 txFull", txFull, 0);
    check("R10 rxFull", rxFull, 0);
    check("R10 rxOverflow", rxOverflow, 0);
    check("R10 sdoOut", sdoOut, 0);
    check("R10 fsyncOut", fsyncOut, 0);

    // Driven sync, both polarities; second word overflows (R7)
    runGen(1, 16'hA5C3, 16'h3C5A, 16'hA5C3);
    clkPol = 1;
    runGen(1, 16'h8001, 16'h7FFE, 16'h8001);
    doRead();

    // Received sync with a word, then without (R9)
    syncDir = 1;
    writeWord(16'h1234);
    runRecv(16'hFEDC, 16'h1234);
    clkPol = 0;
    runRecv(16'h0F0F, 16'h0000);
    doRead();

    // R8 second write replaces first
    writeWord(16'hDEAD);
    writeWord(16'hBEEF);
    runRecv(16'h5555, 16'hBEEF);
    doRead();

    // R1 inactive modes hold the word and stay quiet
    syncDir = 0; masterEn = 1;
    writeWord(16'hC0DE);
    for (int i = 0; i < 6; i++) begin
      waitSample();
      check("R1 no sync while master", fsyncOut, 0);
      check("R1 no data while master", sdoOut, 0);
      check("R1 no oe while master", fsyncOe, 0);
    end
    @(negedge clk); masterEn = 0; frameEn = 0;
    for (int i = 0; i < 3; i++) begin
      waitSample();
      check("R1 no sync while unframed", fsyncOut, 0);
      check("R1 no data while unframed", sdoOut, 0);
    end
    check("R1 word held while inactive", txFull, 1);
    @(negedge clk); frameEn = 1;
    runGen(0, 16'h0000, 16'hA0A0, 16'hC0DE);
    doRead();

    // Constrained random frames
    for (int n = 0; n < 40; n++) begin
      logic [15:0] w, r;
      bit wrote;
      w = 16'($urandom); r = 16'($urandom);
      @(negedge clk);
      clkPol = 1'($urandom % 2);
      syncDir = 1'($urandom % 2);
      if (!syncDir) runGen(1, w, r, w);
      else begin
        wrote = 1'($urandom % 2);
        if (wrote) writeWord(w);
        runRecv(r, txExpect(wrote, w));
      end
      if ($urandom % 3 != 0) doRead();
    end
    finish();
  end

endmodule